// File: doc/BRIEF.md
# DMA Command List Generator

This block converts a single transfer request into the stream of command entries that a descriptor-driven DMA engine reads. A request carries a memory address, a byte count, a fixed device address, a direction, a burst size (given as a power-of-two exponent), a flow-control enable, a 4-bit request-line index and a flag that marks the final segment of a larger transfer. The generator works out how the transfer is split and sends each command out as 32-bit words on a valid/ready stream.

When flow control is on, the transfer is covered first by two-dimensional box commands made of whole bursts. Any tail shorter than one burst then goes into one single command. When flow control is off, the transfer is cut into single commands of at most 65535 bytes. The device-side address stays the same across all commands. The memory-side address moves forward by the bytes each command covers.

Top module: `dma_cmdlist_gen`

## Requirements
- R1: `req_ready` is high only when the generator is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `busy` equals the inverse of `req_ready`. After an accept, `busy` stays high until the final word of the final command has been accepted, or for exactly one cycle when no command results. A request presented while busy has no effect on the output stream.
- R2: In the command word, bits 1:0 give the type: 0 means single and 3 means box. Bit 31 is set only on the final command of a request whose last-segment flag is set.
- R3: With flow control on and `req_dev_to_mem`=1, the request line is placed in command bits 6:3. With flow control on and `req_dev_to_mem`=0, it is placed in bits 10:7. With flow control off, both fields are zero.
- R4: With flow control on and burst = 1<<`req_burst_shift`, box commands are emitted while the remaining length is at least one burst. Each box has rows = min(remaining/burst, 65535), and a box never has zero rows.
- R5: A box is six words, in this order: command, source, destination, row length, row count, row offset. The row length word is {burst, burst} in 16-bit halves. The row count word is {rows, rows}. The row offset word is burst<<16 when memory is the source and 0 when memory is the destination.
- R6: With flow control on, a tail greater than 0 and less than one burst produces one single command with length equal to the tail. A zero-length request produces no command.
- R7: With flow control off, single commands of length min(remaining, 65535) are emitted until the length is used up. A zero-length request gives one single command of length 0. A single is four words, in this order: command, source, destination, length (in bits 15:0).
- R8: When `req_dev_to_mem`=0, the source is the memory address and the destination is the device address; when it is 1, they are swapped. The device address is the same in every command. The memory address advances by the bytes covered by each command.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Generator idle, request can be taken |
| req_mem_addr | input | 32 | Memory-side start address |
| req_dev_addr | input | 32 | Fixed device-side address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_dev_to_mem | input | 1 | 1: device is source; 0: memory is source |
| req_burst_shift | input | 4 | Burst size exponent (burst = 1<<value) |
| req_flow_ctrl | input | 1 | Flow-controlled (box) mode |
| req_line | input | 4 | Request-line index |
| req_last_seg | input | 1 | Request is the final segment |
| cmd_valid | output | 1 | Command word present |
| cmd_ready | input | 1 | Consumer takes the word |
| cmd_word | output | 32 | Command stream word |
| busy | output | 1 | Request in progress |

## Verification
The row cap of 65535 is the condition hardest to reach from the ports. With realistic bursts it needs megabyte transfers and very long streams. The stimulus reaches it with a burst exponent of 0 and a length of 70000, which forces a capped box followed by a second box. The same length with flow control off exercises the cap on single-command length. Backpressure on `cmd_ready` is applied throughout so that word holding is checked at every boundary. A second request is held on the input during a long transfer to show that it is ignored.

// File: rtl/cmdgen_pkg.sv
// Package: shared constants and types for the command list generator.
// Assumes 32-bit command words with 16-bit count fields.
package cmdgen_pkg;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 16;
    localparam int LINE_W  = 4;
    localparam int SHIFT_W = 4;
    localparam int BEAT_W  = 3;

    localparam logic [1:0] TYPE_SINGLE = 2'd0;
    localparam logic [1:0] TYPE_BOX    = 2'd3;

    localparam logic [BEAT_W-1:0] BOX_LAST_BEAT    = 3'd5;
    localparam logic [BEAT_W-1:0] SINGLE_LAST_BEAT = 3'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PLAN = 2'd1,
        ST_EMIT = 2'd2
    } gen_state_e;

    typedef struct packed {
        logic              is_box;
        logic              final_cmd;
        logic              last_flag;
        logic [CNT_W-1:0]  count;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
    } cmd_t;
endpackage

// File: rtl/dma_cmdlist_plan.sv
// Module: dma_cmdlist_plan
// Works out the next command from the bytes still to cover: a box of whole
// bursts, a tail single, or a capped single. Purely combinational.
// Assumes LEN_W > CNT_W and that the caller holds inputs stable while planning.
module dma_cmdlist_plan
    import cmdgen_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic [LEN_W-1:0]   rem,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               flow_ctrl,
    input  logic               first,
    input  logic               dev_to_mem,
    input  logic               last_seg,
    input  logic [WORD_W-1:0]  mem_addr,
    input  logic [WORD_W-1:0]  dev_addr,
    output logic               have_cmd,
    output cmd_t               cmd,
    output logic [LEN_W-1:0]   rem_after,
    output logic [WORD_W-1:0]  mem_next
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'((64'd1 << CNT_W) - 64'd1);

    logic [LEN_W-1:0] units;
    logic [CNT_W-1:0] rows;
    logic [LEN_W-1:0] box_bytes;
    logic [CNT_W-1:0] nfc_len;
    logic [LEN_W-1:0] consumed;

    // Size candidates: whole-burst rows and the capped plain length.
    always_comb begin
        units     = rem >> shift;
        rows      = (units > CAP) ? CAP[CNT_W-1:0] : units[CNT_W-1:0];
        box_bytes = LEN_W'(rows) << shift;
        nfc_len   = (rem > CAP) ? CAP[CNT_W-1:0] : rem[CNT_W-1:0];
    end

    // Choose the command kind and how many bytes it covers.
    always_comb begin
        have_cmd   = 1'b0;
        cmd.is_box = 1'b0;
        cmd.count  = '0;
        consumed   = '0;
        if (flow_ctrl) begin
            if (units != '0) begin
                have_cmd   = 1'b1;
                cmd.is_box = 1'b1;
                cmd.count  = rows;
                consumed   = box_bytes;
            end else if (rem != '0) begin
                have_cmd  = 1'b1;
                cmd.count = rem[CNT_W-1:0];
                consumed  = rem;
            end
        end else if ((rem != '0) || first) begin
            have_cmd  = 1'b1;
            cmd.count = nfc_len;
            consumed  = LEN_W'(nfc_len);
        end
        rem_after     = rem - consumed;
        cmd.final_cmd = (rem_after == '0);
        cmd.last_flag = cmd.final_cmd & last_seg;
        cmd.src       = dev_to_mem ? dev_addr : mem_addr;
        cmd.dst       = dev_to_mem ? mem_addr : dev_addr;
        mem_next      = mem_addr + WORD_W'(consumed);
    end
endmodule

// File: rtl/dma_cmdlist_fmt.sv
// Module: dma_cmdlist_fmt
// Produces the word for a given beat of the current command and flags the
// final beat. Combinational; assumes beat stays within the command's length.
module dma_cmdlist_fmt
    import cmdgen_pkg::*;
(
    input  cmd_t               cmd,
    input  logic [BEAT_W-1:0]  beat,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               dev_to_mem,
    input  logic               flow_ctrl,
    input  logic [LINE_W-1:0]  line,
    output logic [WORD_W-1:0]  word,
    output logic               last_beat
);
    logic [CNT_W-1:0]  burst16;
    logic [WORD_W-1:0] head;

    // Command word: type, request-line field by direction, last flag.
    always_comb begin
        burst16   = CNT_W'(1) << shift;
        head      = '0;
        head[31]  = cmd.last_flag;
        head[1:0] = cmd.is_box ? TYPE_BOX : TYPE_SINGLE;
        if (flow_ctrl) begin
            if (dev_to_mem) head[6:3]  = line;
            else            head[10:7] = line;
        end
    end

    // Beat multiplexer following the box or single word order.
    always_comb begin
        last_beat = (beat == (cmd.is_box ? BOX_LAST_BEAT : SINGLE_LAST_BEAT));
        case (beat)
            3'd0: word = head;
            3'd1: word = cmd.src;
            3'd2: word = cmd.dst;
            3'd3: word = cmd.is_box ? {burst16, burst16} : {{CNT_W{1'b0}}, cmd.count};
            3'd4: word = {cmd.count, cmd.count};
            3'd5: word = dev_to_mem ? '0 : {burst16, {CNT_W{1'b0}}};
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/dma_cmdlist_gen.sv
// Module: dma_cmdlist_gen (top)
// Accepts one transfer request while idle and emits its command list on a
// valid/ready word stream. A plan cycle sits between commands.
// Assumes the consumer obeys valid/ready.
module dma_cmdlist_gen
    import cmdgen_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [31:0]        req_mem_addr,
    input  logic [31:0]        req_dev_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic               req_dev_to_mem,
    input  logic [3:0]         req_burst_shift,
    input  logic               req_flow_ctrl,
    input  logic [3:0]         req_line,
    input  logic               req_last_seg,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [31:0]        cmd_word,
    output logic               busy
);
    gen_state_e          state_q;
    logic [LEN_W-1:0]    rem_q;
    logic [WORD_W-1:0]   mem_q;
    logic [WORD_W-1:0]   dev_q;
    logic                d2m_q;
    logic [SHIFT_W-1:0]  shift_q;
    logic                fc_q;
    logic [LINE_W-1:0]   line_q;
    logic                last_seg_q;
    logic                first_q;
    cmd_t                cmd_q;
    logic [BEAT_W-1:0]   beat_q;

    logic                have_cmd;
    cmd_t                plan_cmd;
    logic [LEN_W-1:0]    rem_after;
    logic [WORD_W-1:0]   mem_next;
    logic                last_beat;

    dma_cmdlist_plan #(.LEN_W(LEN_W)) u_plan (
        .rem        (rem_q),
        .shift      (shift_q),
        .flow_ctrl  (fc_q),
        .first      (first_q),
        .dev_to_mem (d2m_q),
        .last_seg   (last_seg_q),
        .mem_addr   (mem_q),
        .dev_addr   (dev_q),
        .have_cmd   (have_cmd),
        .cmd        (plan_cmd),
        .rem_after  (rem_after),
        .mem_next   (mem_next)
    );

    dma_cmdlist_fmt u_fmt (
        .cmd        (cmd_q),
        .beat       (beat_q),
        .shift      (shift_q),
        .dev_to_mem (d2m_q),
        .flow_ctrl  (fc_q),
        .line       (line_q),
        .word       (cmd_word),
        .last_beat  (last_beat)
    );

    // Handshake outputs decoded from the sequencing state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = (state_q != ST_IDLE);
        cmd_valid = (state_q == ST_EMIT);
    end

    // Sequencer: capture request, plan each command, stream its words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rem_q      <= '0;
            mem_q      <= '0;
            dev_q      <= '0;
            d2m_q      <= 1'b0;
            shift_q    <= '0;
            fc_q       <= 1'b0;
            line_q     <= '0;
            last_seg_q <= 1'b0;
            first_q    <= 1'b0;
            cmd_q      <= '0;
            beat_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        rem_q      <= req_len;
                        mem_q      <= req_mem_addr;
                        dev_q      <= req_dev_addr;
                        d2m_q      <= req_dev_to_mem;
                        shift_q    <= req_burst_shift;
                        fc_q       <= req_flow_ctrl;
                        line_q     <= req_line;
                        last_seg_q <= req_last_seg;
                        first_q    <= 1'b1;
                        state_q    <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    if (have_cmd) begin
                        cmd_q   <= plan_cmd;
                        rem_q   <= rem_after;
                        mem_q   <= mem_next;
                        first_q <= 1'b0;
                        beat_q  <= '0;
                        state_q <= ST_EMIT;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_EMIT: begin
                    if (cmd_ready) begin
                        if (last_beat) begin
                            state_q <= cmd_q.final_cmd ? ST_IDLE : ST_PLAN;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word))); // R9

    AST_NO_EMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (busy && !req_ready)); // R1

    AST_LAST_ONLY_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && beat_q == '0 && cmd_word[31]) |-> (cmd_q.final_cmd && last_seg_q)); // R2

    AST_NONZERO_BOX: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_q.is_box) |-> (cmd_q.count != '0)); // R4

    AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PLAN && have_cmd && plan_cmd.count != '0) |=> (rem_q < $past(rem_q))); // R4
endmodule

// File: tb/dma_cmdlist_gen_test.sv
module dma_cmdlist_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_mem_addr = '0;
    logic [31:0] req_dev_addr = '0;
    logic [31:0] req_len = '0;
    logic        req_dev_to_mem = 1'b0;
    logic [3:0]  req_burst_shift = '0;
    logic        req_flow_ctrl = 1'b0;
    logic [3:0]  req_line = '0;
    logic        req_last_seg = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [31:0] cmd_word;
    logic        busy;

    always #4 clk = ~clk;

    dma_cmdlist_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mem_addr(req_mem_addr), .req_dev_addr(req_dev_addr), .req_len(req_len),
        .req_dev_to_mem(req_dev_to_mem), .req_burst_shift(req_burst_shift),
        .req_flow_ctrl(req_flow_ctrl), .req_line(req_line), .req_last_seg(req_last_seg),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word), .busy(busy)
    );

    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          exp_busy = 1'b0;
    bit          zl_pend = 1'b0;
    bit          stall_mode = 1'b0;
    int          rc = 0;

    function automatic void check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endfunction

    function automatic void push(logic [31:0] w, string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endfunction

    // Behavioural reference: expected words for one accepted request.
    function automatic void build(logic [31:0] mem, logic [31:0] dev, longint len, bit d2m,
                                  int sh, bit fc, int line, bit lastseg);
        longint rem = len;
        longint burst = longint'(1) << sh;
        longint rows, l;
        logic [31:0] m = mem;
        logic [31:0] linef;
        logic [31:0] w;
        bit lastc;
        linef = fc ? (d2m ? 32'(line) << 3 : 32'(line) << 7) : 32'h0; // R3
        if (fc) begin
            while (rem >= burst) begin
                rows = rem / burst;
                if (rows > 65535) rows = 65535;
                rem -= rows * burst;
                lastc = (rem == 0) && lastseg;
                w = 32'd3 | linef | (lastc ? 32'h8000_0000 : 32'h0);
                push(w, "R2");
                push(d2m ? dev : m, "R8");
                push(d2m ? m : dev, "R8");
                push((32'(burst) << 16) | 32'(burst), "R5");
                push((32'(rows) << 16) | 32'(rows), "R4");
                push(d2m ? 32'h0 : 32'(burst) << 16, "R5");
                m += 32'(rows * burst);
            end
            if (rem > 0) begin
                w = linef | (lastseg ? 32'h8000_0000 : 32'h0);
                push(w, "R2");
                push(d2m ? dev : m, "R8");
                push(d2m ? m : dev, "R8");
                push(32'(rem), "R6");
            end
        end else begin
            do begin
                l = (rem > 65535) ? 65535 : rem;
                rem -= l;
                w = ((rem == 0) && lastseg) ? 32'h8000_0000 : 32'h0;
                push(w, "R2");
                push(d2m ? dev : m, "R8");
                push(d2m ? m : dev, "R8");
                push(32'(l), "R7");
                m += 32'(l);
            end while (rem > 0);
        end
    endfunction

    // Per-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy === exp_busy, "R1 busy", 32'(busy), 32'(exp_busy));
            check(req_ready === !busy, "R1 ready", 32'(req_ready), 32'(!busy));
            if (cmd_valid && exp_q.size() == 0)
                check(1'b0, "R1 unexpected word", cmd_word, 32'h0);
            if (cmd_valid && cmd_ready && exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(cmd_word === e, t, cmd_word, e);
                if (exp_q.size() == 0) exp_busy = 1'b0;
            end
            if (zl_pend) begin
                exp_busy = 1'b0;
                zl_pend  = 1'b0;
            end
            if (req_valid && req_ready) begin
                build(req_mem_addr, req_dev_addr, longint'(req_len), req_dev_to_mem,
                      int'(req_burst_shift), req_flow_ctrl, int'(req_line), req_last_seg);
                exp_busy = 1'b1;
                if (exp_q.size() == 0) zl_pend = 1'b1;
            end
        end
    end

    // Consumer backpressure pattern (R9 holding is exercised by stalls).
    always @(posedge clk) begin
        #1;
        rc++;
        cmd_ready = stall_mode ? ((rc % 7) != 3 && (rc % 5) != 1) : 1'b1;
    end

    task automatic issue(logic [31:0] mem, logic [31:0] dev, int len, bit d2m,
                         int sh, bit fc, int line, bit lastseg);
        forever begin
            @(posedge clk); #1;
            if (req_ready) break;
        end
        req_mem_addr = mem; req_dev_addr = dev; req_len = 32'(len);
        req_dev_to_mem = d2m; req_burst_shift = 4'(sh); req_flow_ctrl = fc;
        req_line = 4'(line); req_last_seg = lastseg; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        do begin
            @(posedge clk); #1;
        end while (busy || exp_q.size() != 0);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(req_ready === 1'b1, "R1 reset ready", 32'(req_ready), 32'h1);
        check(busy === 1'b0, "R1 reset busy", 32'(busy), 32'h0);
        check(cmd_valid === 1'b0, "R9 reset valid", 32'(cmd_valid), 32'h0);
        rst_n = 1'b1;
        // R4 R5 R6: box of 6 rows, tail of 4, memory to device
        issue(32'h1000_0000, 32'hA000_0040, 100, 1'b0, 4, 1'b1, 5, 1'b1);
        wait_done();
        // R3 R5: device to memory, exact bursts, zero row offset
        stall_mode = 1'b1;
        issue(32'h2000_0100, 32'hB000_0000, 64, 1'b1, 5, 1'b1, 9, 1'b1);
        wait_done();
        // R6: shorter than one burst
        issue(32'h3000_0000, 32'hC000_0010, 10, 1'b1, 4, 1'b1, 3, 1'b1);
        wait_done();
        // R4: row cap reached with burst of 1
        issue(32'h4000_0000, 32'hD000_0000, 70000, 1'b0, 0, 1'b1, 15, 1'b1);
        wait_done();
        // R7 R8: capped single lengths, no flow control
        issue(32'h5000_0000, 32'hE000_0004, 70000, 1'b1, 4, 1'b0, 7, 1'b1);
        wait_done();
        // R7: zero length gives one zero-length single
        issue(32'h6000_0000, 32'hE000_0008, 0, 1'b0, 4, 1'b0, 0, 1'b1);
        wait_done();
        // R6 R1: zero length with flow control gives nothing
        issue(32'h6100_0000, 32'hE000_000C, 0, 1'b0, 4, 1'b1, 2, 1'b1);
        wait_done();
        // R2: not the last segment, no last flag anywhere
        issue(32'h7000_0000, 32'hF000_0000, 200, 1'b0, 6, 1'b1, 1, 1'b0);
        wait_done();
        // R1: request held while busy is ignored
        issue(32'h8000_0000, 32'h9000_0000, 300, 1'b0, 4, 1'b1, 4, 1'b1);
        req_mem_addr = 32'hDEAD_0000; req_len = 32'd8; req_flow_ctrl = 1'b0;
        req_valid = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        req_valid = 1'b0;
        wait_done();
        check(exp_q.size() == 0, "R1 queue drained", 32'(exp_q.size()), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog: actual %h expected %h", 32'(busy), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule